// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a free-running input clock into the two timing strobes a UART datapath needs: a sample strobe at the oversampled line rate and a bit strobe at the serial bit rate. The input clock is divided by a rational number. The integer part is a 16-bit value, written as two bytes. A 4-bit fraction adds sixteenths to it. The resulting sample strobe is then divided again by a run-time selectable oversampling ratio of 16, 8 or 4. The 4x ratio lets the same input clock reach bit rates four times higher than the 16x setting.

The fraction works through a small phase accumulator. Each time the integer divider completes a period, the fraction is added to the accumulator. A carry out of the accumulator makes the following period one input clock longer. Over 16 periods, the total length is therefore 16 times the integer divisor plus the fraction. A transmitter and a receiver each instantiate their own copy, so the two rates are set independently. Any change to the divisor bytes, the fraction or the ratio select restarts every counter from zero. A new setting therefore never produces a truncated first period.

Top module: `frac_baud_gen`

## Requirements
- R1: The integer divisor D is {div_hi, div_lo}, usable from 1 to 65535. With a fraction of 0, consecutive sample strobes are exactly D input clocks apart.
- R2: With fraction F (0..15), sample period k (k >= 2, counted from a restart) lasts D + floor((k-1)F/16) - floor((k-2)F/16) clocks. Any 16 consecutive periods after a restart therefore sum to 16D + F.
- R3: sample_tick is a single-cycle pulse. Whenever D >= 2, it is never high in two consecutive cycles.
- R4: osr_sel selects the ratio N as follows: 2'b00 gives 16, 2'b01 gives 8, 2'b10 gives 4, and 2'b11 is treated as 16. bit_tick is high together with every Nth sample strobe after a restart, and with no other.
- R5: bit_tick is never high unless sample_tick is high in the same cycle.
- R6: A divisor of 0 disables the block. While D = 0, neither strobe is produced.
- R7: While en is low, no strobe is produced. After en rises (at the clock edge that first sees en = 1), the first sample strobe is visible after the D-th rising edge, counting that edge as the first.
- R8: A change of div_lo, div_hi, frac or osr_sel restarts the divider, the accumulator and the ratio counter. No strobe follows the edge that sees the change. The first new sample strobe is visible after the (D+1)-th rising edge, counting that edge as the first. This holds even if an old strobe was due at that same edge.
- R9: During reset both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds all counters at zero |
| div_lo | input | BYTE_W | Low byte of integer divisor |
| div_hi | input | BYTE_W | High byte of integer divisor |
| frac | input | FRAC_W | Fractional divisor in sixteenths |
| osr_sel | input | 2 | Oversampling ratio select |
| sample_tick | output | 1 | One-clock strobe at the oversampled rate |
| bit_tick | output | 1 | One-clock strobe at the bit rate |

## Verification
Two events can land on the same clock edge: a configuration restart, and the period-end wrap (together with the bit strobe that may ride on it). The bench provokes this collision deliberately. It waits for a sample strobe and counts D-1 further clocks. It then changes the divisor so the change lands exactly on the edge where the old strobe was due. It then checks that no strobe appears on that edge and that the first new strobe arrives D'+1 edges later. A second coincidence, a stretched fractional period ending on the Nth sample of a bit, arises in the random cases. There, both the period length and the bit-strobe placement are compared with the closed-form sequence.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

   typedef enum logic [1:0] {
      OSR_X16 = 2'b00,
      OSR_X8  = 2'b01,
      OSR_X4  = 2'b10,
      OSR_RSV = 2'b11
   } osr_sel_e;

   localparam int unsigned OSR_MAX   = 16;
   localparam int unsigned OSR_CNT_W = $clog2(OSR_MAX);

   function automatic logic [OSR_CNT_W-1:0] osr_last_idx(input logic [1:0] sel);
      case (osr_sel_e'(sel))
         OSR_X8:  return OSR_CNT_W'(7);
         OSR_X4:  return OSR_CNT_W'(3);
         default: return OSR_CNT_W'(OSR_MAX - 1);
      endcase
   endfunction

endpackage

// File: rtl/baud_cfg_track.sv
module baud_cfg_track #(
   parameter int CFG_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg,
   output logic             restart
);

   logic [CFG_W-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else begin
         cfg_q <= cfg;
      end
   end

   assign restart = (cfg != cfg_q);

endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
   parameter int DIV_W   = 16,
   parameter int FRAC_W  = 4,
   parameter bit FRAC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              active,
   input  logic [DIV_W-1:0]  div,
   input  logic [FRAC_W-1:0] frac,
   output logic              wrap
);

   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] cnt;
   logic             stretch;
   logic             carry;
   logic             at_end;

   assign at_end = stretch ? (cnt == div) : (cnt == div - ONE);
   assign wrap   = active && !clear && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear || !active || wrap) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + ONE;
      end
   end

   generate
      if (FRAC_EN) begin : g_frac
         logic [FRAC_W-1:0] acc;
         logic [FRAC_W:0]   sum;

         assign sum   = {1'b0, acc} + {1'b0, frac};
         assign carry = sum[FRAC_W];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc     <= '0;
               stretch <= 1'b0;
            end else if (clear || !active) begin
               acc     <= '0;
               stretch <= 1'b0;
            end else if (wrap) begin
               acc     <= sum[FRAC_W-1:0];
               stretch <= carry;
            end
         end
      end else begin : g_int_only
         logic unused_frac;
         assign unused_frac = ^frac;
         assign carry       = 1'b0;
         assign stretch     = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/baud_osr_div.sv
module baud_osr_div
   import baud_gen_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       step,
   input  logic [1:0] sel,
   output logic       last
);

   logic [OSR_CNT_W-1:0] cnt;
   logic [OSR_CNT_W-1:0] top_idx;

   assign top_idx = osr_last_idx(sel);
   assign last    = step && (cnt == top_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= last ? '0 : cnt + OSR_CNT_W'(1);
      end
   end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
   parameter int BYTE_W  = 8,
   parameter int FRAC_W  = 4,
   parameter bit FRAC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [BYTE_W-1:0] div_lo,
   input  logic [BYTE_W-1:0] div_hi,
   input  logic [FRAC_W-1:0] frac,
   input  logic [1:0]        osr_sel,
   output logic              sample_tick,
   output logic              bit_tick
);

   localparam int DIV_W = 2 * BYTE_W;
   localparam int CFG_W = DIV_W + FRAC_W + 2;

   generate
      if (BYTE_W < 2 || BYTE_W > 16) begin : g_bad_byte
         $error("frac_baud_gen: BYTE_W out of range");
      end
      if (FRAC_W < 1 || FRAC_W > 8) begin : g_bad_frac
         $error("frac_baud_gen: FRAC_W out of range");
      end
   endgenerate

   logic [DIV_W-1:0] div;
   logic             restart;
   logic             active;
   logic             wrap;
   logic             osr_last;

   assign div    = {div_hi, div_lo};
   assign active = en && (div != '0);

   baud_cfg_track #(.CFG_W(CFG_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg     ({div, frac, osr_sel}),
      .restart (restart)
   );

   baud_frac_div #(
      .DIV_W   (DIV_W),
      .FRAC_W  (FRAC_W),
      .FRAC_EN (FRAC_EN)
   ) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (restart),
      .active (active),
      .div    (div),
      .frac   (frac),
      .wrap   (wrap)
   );

   baud_osr_div u_osr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (restart || !active),
      .step  (wrap),
      .sel   (osr_sel),
      .last  (osr_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_tick <= 1'b0;
         bit_tick    <= 1'b0;
      end else begin
         sample_tick <= wrap;
         bit_tick    <= osr_last;
      end
   end

endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
   parameter int BYTE_W = 8,
   parameter int FRAC_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [BYTE_W-1:0] div_lo,
   input logic [BYTE_W-1:0] div_hi,
   input logic [FRAC_W-1:0] frac,
   input logic [1:0]        osr_sel,
   input logic              sample_tick,
   input logic              bit_tick
);

   logic div_zero;
   logic div_ge2;
   assign div_zero = ({div_hi, div_lo} == '0);
   assign div_ge2  = ({div_hi, div_lo} > 2 * BYTE_W'(1) - 1);

   p_bit_inside_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> sample_tick);

   p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_tick && div_ge2) |=> !sample_tick);

   p_zero_div_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      div_zero |=> (!sample_tick && !bit_tick));

   p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!sample_tick && !bit_tick));

   p_restart_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({div_hi, div_lo, frac, osr_sel}) |=> !sample_tick);

   always @(negedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r9: assert (!sample_tick && !bit_tick);
      end
   end

endmodule

bind frac_baud_gen frac_baud_gen_chk #(.BYTE_W(BYTE_W), .FRAC_W(FRAC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en          (en),
   .div_lo      (div_lo),
   .div_hi      (div_hi),
   .frac        (frac),
   .osr_sel     (osr_sel),
   .sample_tick (sample_tick),
   .bit_tick    (bit_tick)
);

// File: tb/frac_baud_gen_tb_top.sv
`timescale 1ns/1ps
module frac_baud_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] div_lo = 8'd0;
   logic [7:0] div_hi = 8'd0;
   logic [3:0] frac = 4'd0;
   logic [1:0] osr_sel = 2'd0;
   logic       sample_tick;
   logic       bit_tick;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int seed_val;

   always #2 clk = ~clk;

   frac_baud_gen dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .div_lo(div_lo), .div_hi(div_hi),
      .frac(frac), .osr_sel(osr_sel), .sample_tick(sample_tick), .bit_tick(bit_tick)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: act=%0d exp<=%0d", cyc, 150000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   function automatic int osr_n(input int sel);
      if (sel == 1) return 8;
      if (sel == 2) return 4;
      return 16;
   endfunction

   function automatic int exp_period(input int d, input int f, input int k);
      return d + ((k - 1) * f) / 16 - ((k - 2) * f) / 16;
   endfunction

   task automatic set_cfg(input int d, input int f, input int sel);
      {div_hi, div_lo} = 16'(d);
      frac = 4'(f);
      osr_sel = 2'(sel);
   endtask

   // Watch nt sample strobes; first one expected at cycle first_lat.
   task automatic watch(input int d, input int f, input int sel, input int nt, input int first_lat);
      int c = 0;
      int k = 0;
      int last = 0;
      int sum16 = 0;
      bit prev = 1'b0;
      bit r3_ok = 1'b1;
      int n = osr_n(sel);
      while (k < nt && c < 4 * (d + 2) * (nt + 1)) begin
         @(negedge clk);
         c++;
         if (sample_tick && prev && d >= 2) r3_ok = 1'b0;
         prev = sample_tick;
         if (sample_tick) begin
            k++;
            if (k == 1) begin
               chk(c == first_lat, "R8/R7 first strobe latency", c, first_lat);
            end else begin
               chk(c - last == exp_period(d, f, k), (f == 0) ? "R1 period" : "R2 period",
                   c - last, exp_period(d, f, k));
               if (k >= 2 && k <= 17) sum16 += c - last;
            end
            chk(bit_tick == ((k % n) == 0), "R4 bit strobe placement", bit_tick, (k % n) == 0);
            last = c;
         end else if (bit_tick) begin
            chk(1'b0, "R5 lone bit strobe", 1, 0);
         end
      end
      chk(k == nt, "R1 strobe count", k, nt);
      chk(r3_ok, "R3 single-cycle strobe", r3_ok, 1);
      if (nt >= 17) chk(sum16 == 16 * d + f, "R2 sixteen-period sum", sum16, 16 * d + f);
   endtask

   task automatic quiet(input int ncyc, input string req);
      bit seen = 1'b0;
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk);
         if (sample_tick || bit_tick) seen = 1'b1;
      end
      chk(!seen, req, seen, 0);
   endtask

   task automatic run_case(input int d, input int f, input int sel, input int nt);
      @(negedge clk);
      set_cfg(0, 0, 0);
      quiet(3, "R6 zero divisor quiet");
      set_cfg(d, f, sel);
      watch(d, f, sel, nt, d + 1);
   endtask

   initial begin
      seed_val = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      chk(!sample_tick && !bit_tick, "R9 reset state", sample_tick, 0);
      rst_n = 1'b1;
      en = 1'b1;

      // Directed corners
      run_case(1, 0, 2, 12);          // every-cycle strobe, 4x
      run_case(1, 15, 0, 34);         // heaviest stretch on smallest divisor
      run_case(3, 8, 1, 20);          // half-step fraction, 8x
      run_case(258, 5, 2, 9);         // high byte in use
      run_case(2, 1, 3, 34);          // reserved select acts as 16x

      // R7: enable gating
      @(negedge clk);
      en = 1'b0;
      set_cfg(4, 0, 2);
      quiet(12, "R7 disabled quiet");
      en = 1'b1;
      watch(4, 0, 2, 6, 4);

      // R8 collision: change lands on the edge where an old strobe is due
      run_case(5, 0, 1, 3);
      repeat (4) @(negedge clk);
      set_cfg(3, 0, 1);
      watch(3, 0, 1, 9, 4);

      // Constrained random
      for (int i = 0; i < 24; i++) begin
         int d = 1 + int'($urandom % 40);
         int f = int'($urandom % 16);
         int s = int'($urandom % 4);
         run_case(d, f, s, 2 * osr_n(s) + 1);
      end

      @(negedge clk);
      set_cfg(0, 7, 1);
      quiet(20, "R6 zero divisor with fraction");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule